// File: doc/BRIEF.md
# Boot History Status Register

This block is a 16-bit status word that records how the last configuration attempts of a multi-image boot flow ended. It watches an end-of-startup strobe, three error strobes (CRC failure, ID-code mismatch, watchdog time-out) and a fallback indication. Each time one of those events is seen, it captures the outcome into a current-attempt group of six bits. A saturating strike counter tallies the errors. The whole word is always visible on a read port.

The word is cleared only by the power-on reset or by the external program reset. The internal reprogram command does not clear it, so a new image loaded by that command can inspect what happened before. The reprogram command and the fallback indication arm a one-bit attempt flag. While that flag is set, every later event also writes a second status group. This second group shows the outcome of the reload or fallback attempt. Neither the reprogram command nor the arming of the flag changes the visible word by itself.

All updates are registered on the rising clock edge. A value captured at edge k can be read on the read port after edge k.

Top module: `boot_hist_reg`

## Requirements
- R1: When `rst_n` or `prog_n` is low at a clock edge, the whole word reads 0x0000 after that edge and the attempt flag is cleared.
- R2: A cycle with `reprog_cmd` high and no event leaves the word unchanged.
- R3: An event is `eos` or any error strobe high at an edge. It writes group 0 into bits 5:0 with these fields: bit 5 = `err_crc`, bit 4 = `err_id`, bit 3 = `err_wdt`, bit 1 = `fallback`, bit 0 = 1 (valid).
- R4: Group 1 in bits 11:6 has the same field order: bit 11 CRC, bit 10 ID, bit 9 watchdog, bit 7 fallback, bit 6 valid. An event writes group 1 only if the attempt flag was already set before that edge. Otherwise group 1 holds its value.
- R5: The attempt flag is set by `reprog_cmd` or `fallback` high at an edge. It takes effect for events at later edges, and only R1 clears it.
- R6: The strike count in bits 15:12 grows by the number of error strobes high at an edge and saturates at 15.
- R7: Error strobes that arrive together set all of their flags in the same update.
- R8: Reserved bits 8 and 2 always read 0.
- R9: Both valid bits read 0 after a clear. A group's valid bit reads 1 once that group has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| prog_n | input | 1 | External program reset, active low, synchronous |
| reprog_cmd | input | 1 | Internal reprogram command strobe; arms the attempt flag |
| eos | input | 1 | End-of-startup strobe |
| err_crc | input | 1 | CRC error strobe |
| err_id | input | 1 | ID-code mismatch strobe |
| err_wdt | input | 1 | Watchdog time-out strobe |
| fallback | input | 1 | Fallback indication; recorded and arms the attempt flag |
| status_word | output | 16 | Read port: strike count, group 1, group 0 |

## Verification
The arming of the attempt flag and a recording event can fall in the same cycle. For example, `reprog_cmd` or `fallback` can be high in the same cycle as `eos` or an error strobe. The bench sweeps every combination of the three error strobes, `fallback` and `eos`, both with the flag armed beforehand and with it clear. This includes cases where `fallback` both arms the flag and is recorded in the same edge. A bench model decides whether group 1 may change: it must not move on the arming edge and must take the next event. A second clash, several error strobes together near the counter's limit, is judged against the model's saturated sum.

// File: rtl/boot_hist_pkg.sv
// Package: shared widths and the six-bit status group layout for the
// boot history status register. Field order inside a group is fixed
// because readers decode the word by bit position.
package boot_hist_pkg;

    localparam int N_ERR  = 3;                 // CRC, ID-code, watchdog
    localparam int CNT_W  = 4;                 // strike count width
    localparam int GRP_W  = 6;                 // bits per status group
    localparam int N_GRP  = 2;                 // current and previous
    localparam int WORD_W = CNT_W + N_GRP * GRP_W;

    // Error vector bit positions
    localparam int E_WDT = 0;
    localparam int E_ID  = 1;
    localparam int E_CRC = 2;

    typedef struct packed {
        logic crc;    // MSB of group
        logic idc;
        logic wdt;
        logic rsvd;   // always zero
        logic fb;     // 1: fell back to image address zero
        logic valid;  // LSB of group
    } grp_t;

    // Build the group value for the present status.
    function automatic grp_t make_grp(input logic [N_ERR-1:0] err, input logic fb);
        grp_t g;
        g.crc   = err[E_CRC];
        g.idc   = err[E_ID];
        g.wdt   = err[E_WDT];
        g.rsvd  = 1'b0;
        g.fb    = fb;
        g.valid = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/bh_event_decode.sv
// Module: bh_event_decode
// Decides whether the present cycle is a recording event and forms the
// group value to store. It also holds the attempt flag that enables
// writes to the second group.
// Assumes: strobes are single-cycle or level, synchronous to clk; clear
// is the combined synchronous reset (active high).
module bh_event_decode
    import boot_hist_pkg::*;
(
    input  logic             clk,
    input  logic             clear,
    input  logic             eos,
    input  logic [N_ERR-1:0] err,
    input  logic             fallback,
    input  logic             reprog_cmd,
    output logic             event_hit,
    output logic             attempt_q,
    output grp_t             wr_val
);

    // Purpose: an event is end of startup or any error strobe.
    always_comb begin
        event_hit = eos | (|err);
        wr_val    = make_grp(err, fallback);
    end

    // Purpose: attempt flag, set by a reload request, cleared only by resets.
    always_ff @(posedge clk) begin
        if (clear)
            attempt_q <= 1'b0;
        else if (reprog_cmd || fallback)
            attempt_q <= 1'b1;
    end

    // R5: once armed, the flag stays set until a reset
    p_attempt_sticky_r5: assert property (@(posedge clk) disable iff (clear)
        attempt_q |=> attempt_q);

    // R5: the flag rises only after a request
    p_attempt_cause_r5: assert property (@(posedge clk) disable iff (clear)
        (!attempt_q && !reprog_cmd && !fallback) |=> !attempt_q);

endmodule

// File: rtl/bh_status_group.sv
// Module: bh_status_group
// One six-bit status group. It loads the supplied group value when
// wr_en is high and otherwise holds its value.
// Assumes: clear is the synchronous combined reset (active high).
module bh_status_group
    import boot_hist_pkg::*;
(
    input  logic clk,
    input  logic clear,
    input  logic wr_en,
    input  grp_t wr_val,
    output grp_t q
);

    // Purpose: group storage with clear-to-zero and write-enable.
    always_ff @(posedge clk) begin
        if (clear)
            q <= '0;
        else if (wr_en)
            q <= wr_val;
    end

    // R9: a written group reads valid
    p_valid_on_write_r9: assert property (@(posedge clk) disable iff (clear)
        wr_en |=> q.valid);

    // R4: without a write the group holds
    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (clear)
        !wr_en |=> $stable(q));

    // R8: reserved bit never set
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (clear)
        1'b1 |=> (q.rsvd == 1'b0));

endmodule

// File: rtl/bh_strike_ctr.sv
// Module: bh_strike_ctr
// Saturating strike counter. It adds the number of error strobes high
// in the present cycle and stops at its all-ones value.
// Assumes: clear is the synchronous combined reset (active high).
module bh_strike_ctr #(
    parameter int CW = 4,
    parameter int NE = 3
) (
    input  logic          clk,
    input  logic          clear,
    input  logic [NE-1:0] err,
    output logic [CW-1:0] cnt
);

    localparam int        NW      = $clog2(NE + 1);
    localparam logic [CW:0] CNT_MAX = {1'b0, {CW{1'b1}}};

    logic [NW-1:0] n_err;
    logic [CW:0]   sum;

    // Purpose: count the error strobes raised this cycle.
    always_comb begin
        n_err = '0;
        for (int k = 0; k < NE; k++)
            n_err = n_err + NW'(err[k]);
        sum = {1'b0, cnt} + (CW+1)'(n_err);
    end

    // Purpose: saturating accumulate.
    always_ff @(posedge clk) begin
        if (clear)
            cnt <= '0;
        else if (sum > CNT_MAX)
            cnt <= {CW{1'b1}};
        else
            cnt <= sum[CW-1:0];
    end

    // R6: counter stays at its limit
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (clear)
        (cnt == {CW{1'b1}}) |=> (cnt == {CW{1'b1}}));

    // R6: never decreases without a clear
    p_monotonic_r6: assert property (@(posedge clk) disable iff (clear)
        1'b1 |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/boot_hist_reg.sv
// Module: boot_hist_reg (top)
// Boot history status word: strike count [15:12], previous/reload
// attempt group [11:6], current attempt group [5:0]. Cleared only by the
// power-on reset or the external program reset. The internal reprogram
// command arms the second group and does not touch the word.
// Assumes: all inputs synchronous to clk; both resets active low, sync.
module boot_hist_reg
    import boot_hist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_n,
    input  logic              reprog_cmd,
    input  logic              eos,
    input  logic              err_crc,
    input  logic              err_id,
    input  logic              err_wdt,
    input  logic              fallback,
    output logic [WORD_W-1:0] status_word
);

    logic             clear;
    logic [N_ERR-1:0] err;
    logic             event_hit;
    logic             attempt_q;
    grp_t             wr_val;
    logic [N_GRP-1:0] grp_we;
    grp_t             grp_q [N_GRP];
    logic [CNT_W-1:0] strikes;

    // Purpose: combine resets and gather error strobes into a vector.
    always_comb begin
        clear        = !rst_n || !prog_n;
        err          = '0;
        err[E_CRC]   = err_crc;
        err[E_ID]    = err_id;
        err[E_WDT]   = err_wdt;
        grp_we[0]    = event_hit;
        grp_we[1]    = event_hit && attempt_q;
    end

    bh_event_decode u_decode (
        .clk        (clk),
        .clear      (clear),
        .eos        (eos),
        .err        (err),
        .fallback   (fallback),
        .reprog_cmd (reprog_cmd),
        .event_hit  (event_hit),
        .attempt_q  (attempt_q),
        .wr_val     (wr_val)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        bh_status_group u_grp (
            .clk    (clk),
            .clear  (clear),
            .wr_en  (grp_we[g]),
            .wr_val (wr_val),
            .q      (grp_q[g])
        );
    end

    bh_strike_ctr #(.CW(CNT_W), .NE(N_ERR)) u_strike (
        .clk   (clk),
        .clear (clear),
        .err   (err),
        .cnt   (strikes)
    );

    // Purpose: assemble the read word, group 0 in the low bits.
    always_comb begin
        status_word[GRP_W-1:0] = grp_q[0];
        for (int g = 1; g < N_GRP; g++)
            status_word[g*GRP_W +: GRP_W] = grp_q[g];
        status_word[WORD_W-1 -: CNT_W] = strikes;
    end

    // R1: program reset clears the whole word
    p_prog_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |=> (status_word == '0));

    // R2: reprogram command alone changes nothing visible
    p_reprog_quiet_r2: assert property (@(posedge clk) disable iff (clear)
        (reprog_cmd && !eos && !err_crc && !err_id && !err_wdt) |=> $stable(status_word));

    // R3: an event marks the current group valid with its fallback flag
    p_grp0_capture_r3: assert property (@(posedge clk) disable iff (clear)
        (eos || err_crc || err_id || err_wdt) |=> (status_word[0] && (status_word[1] == $past(fallback))));

    // R7: simultaneous errors all land together
    p_multi_err_r7: assert property (@(posedge clk) disable iff (clear)
        (err_crc && err_id && err_wdt) |=> (status_word[5:3] == 3'b111));

endmodule

// File: tb/tb_boot_hist_reg.sv
`timescale 1ns/1ps
// Bench: near-exhaustive sweep of strobe combinations against an
// arithmetic model of the status word.
module tb_boot_hist_reg;

    logic        clk = 1'b0;
    logic        rst_n, prog_n, reprog_cmd, eos, err_crc, err_id, err_wdt, fallback;
    logic [15:0] status_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] exp_w;
    logic        exp_att;

    always #4 clk = ~clk;   // 125 MHz

    boot_hist_reg dut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .reprog_cmd(reprog_cmd),
        .eos(eos), .err_crc(err_crc), .err_id(err_id), .err_wdt(err_wdt),
        .fallback(fallback), .status_word(status_word)
    );

    task automatic check(input string tag);
        n_chk++;
        if (status_word !== exp_w) begin
            n_fail++;
            $display("FAIL %s: status_word=%h expected=%h", tag, status_word, exp_w);
        end
        n_chk++;
        if ((status_word & 16'h0104) !== 16'h0000) begin
            n_fail++;
            $display("FAIL R8: reserved bits=%h expected=0000", status_word & 16'h0104);
        end
    endtask

    // Drive one cycle at negedge, update model at posedge, check at next negedge.
    task automatic cycle(input logic r, input logic p, input logic rp, input logic e,
                         input logic c, input logic i, input logic w, input logic f,
                         input string tag);
        logic [5:0] g;
        int         s;
        rst_n = r; prog_n = p; reprog_cmd = rp; eos = e;
        err_crc = c; err_id = i; err_wdt = w; fallback = f;
        @(posedge clk);
        if (!r || !p) begin
            exp_w   = 16'h0000;
            exp_att = 1'b0;
        end else begin
            g = {c, i, w, 1'b0, f, 1'b1};
            if (e || c || i || w) begin
                if (exp_att) exp_w[11:6] = g;
                exp_w[5:0] = g;
            end
            s = int'(exp_w[15:12]) + int'(c) + int'(i) + int'(w);
            exp_w[15:12] = (s > 15) ? 4'hF : 4'(s);
            if (rp || f) exp_att = 1'b1;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(input string tag);
        cycle(1, 1, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        exp_w = 16'h0000; exp_att = 1'b0;
        rst_n = 0; prog_n = 1; reprog_cmd = 0; eos = 0;
        err_crc = 0; err_id = 0; err_wdt = 0; fallback = 0;
        @(negedge clk);
        cycle(0, 1, 0, 0, 0, 0, 0, 0, "R1 power-on clear");
        cycle(0, 1, 0, 0, 0, 0, 0, 0, "R9 valid bits zero after reset");
        idle("R1 hold after reset");

        // R3 R4 R5 R7: sweep every strobe combination, flag armed or not
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 32; v++) begin
                cycle(1, 0, 0, 0, 0, 0, 0, 0, "R1 program clear");
                if (a == 1) cycle(1, 1, 1, 0, 0, 0, 0, 0, "R2 R5 arm by reprog");
                cycle(1, 1, 0, v[4], v[3], v[2], v[1], v[0], "R3 R4 R7 event capture");
                idle("R4 hold after event");
                cycle(1, 1, 0, 1, 0, 0, 0, 0, "R4 R5 second eos");
            end
        end

        // R5: arming and event on the same edge must not write group 1
        cycle(0, 1, 0, 0, 0, 0, 0, 0, "R1 power-on clear again");
        cycle(1, 1, 1, 1, 1, 0, 0, 0, "R5 arm and event same edge");
        cycle(1, 1, 0, 0, 0, 1, 0, 0, "R5 group 1 written next event");
        // R2: reprog with data present leaves word intact
        cycle(1, 1, 1, 0, 0, 0, 0, 0, "R2 reprog does not clear");
        cycle(1, 1, 1, 0, 0, 0, 0, 0, "R2 reprog repeated");

        // R6: saturation with triple strobes
        for (int k = 0; k < 6; k++)
            cycle(1, 1, 0, 0, 1, 1, 1, 0, "R6 R7 strike count saturation");
        cycle(1, 1, 0, 1, 0, 0, 0, 0, "R6 saturated count holds");

        // R1/R5: reset clears the flag; later event leaves group 1 empty
        cycle(1, 0, 0, 0, 0, 0, 0, 0, "R1 program clear");
        cycle(1, 1, 0, 1, 0, 0, 0, 0, "R5 flag cleared by reset");
        cycle(1, 1, 0, 0, 1, 0, 0, 1, "R5 fallback arms flag");
        cycle(1, 1, 0, 1, 0, 0, 0, 0, "R4 group 1 written after fallback");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule